// File: doc/BRIEF.md
# Banked GPIO register controller

This block is a memory-mapped general-purpose I/O controller for 128 pins, split into four banks of 32. A synchronous register port lets software configure each pin as input or output, raise or drop output bits through separate write-only set and clear words, read a merged pin level, and keep two alternate-function words per bank as plain storage. The register map is irregular: the first three banks sit at consecutive words, while the level, direction, set and clear words of the fourth bank are relocated into a high window.

Pad inputs enter through a two-flop synchroniser before the level readback sees them. Each pad output carries the output latch gated by its direction bit, so a pin configured as input always drives 0. Reads return data one cycle after the request, with a one-cycle valid strobe. Accesses to offsets inside the 512-byte window that decode to no register are dropped and set a sticky error flag. Accesses at or beyond 0x200 are dropped silently.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Pin n maps to bank n>>5, bit n&31, and is pad_in[n] and pad_out[n].
- R2: Byte offsets per bank 0..3: level 0x000/0x004/0x008/0x100, direction 0x00C/0x010/0x014/0x10C, set 0x018/0x01C/0x020/0x118, clear 0x024/0x028/0x02C/0x124. The level word is read-only and writes to it have no effect.
- R3: Alternate-function words are read/write storage at low 0x054+8*bank and high 0x058+8*bank.
- R4: A write to a set word ORs the written value into that bank's output latch.
- R5: A write to a clear word clears each latch bit where the written value is 1 and leaves the others.
- R6: Reads of set and clear words return zero.
- R7: A level read returns the latch bit where the direction bit is 1 (output) and the synchronised input where it is 0.
- R8: pad_out equals the output latch ANDed with the direction bits.
- R9: Requests at byte offsets 0x200 or above change no state, return zero and do not raise the error flag.
- R10: Requests below 0x200 that match no register (including non-word-aligned ones) return zero, change no state and set err_flag, which stays set until reset.
- R11: After reset all direction, latch and alternate-function words are zero, pad_out is zero and err_flag is low.
- R12: Read data and rd_valid appear one cycle after the request; pad_in passes two flops before a level read can see it, so a read issued in the same cycle as a pad change returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the request |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| err_flag | output | 1 | Sticky flag for unmapped accesses below 0x200 |
| pad_in | input | 128 | Asynchronous pad input levels |
| pad_out | output | 128 | Pad output values |

## Verification
The assertions assume the request strobe and its fields are stable and free of X in every cycle outside reset, and that pad_in may change at any time because it is resynchronised. The stimulus drives requests and pads only on the falling clock edge, holds each request for exactly one cycle, and draws offsets from both the mapped register set and the full 12-bit range so that unmapped and out-of-window accesses occur alongside legal ones. After each pad change the bench waits past the synchroniser before relying on the level readback, except in the directed latency case.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int NBANK   = 4;
    localparam int BANK_W  = 32;
    localparam int NPIN    = NBANK * BANK_W;
    localparam int OFF_W   = 9;
    localparam int BSEL_W  = $clog2(NBANK);
    localparam int WINDOW  = 1 << OFF_W;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_LEVEL = 3'd1,
        K_DIR   = 3'd2,
        K_SET   = 3'd3,
        K_CLR   = 3'd4,
        K_ALTLO = 3'd5,
        K_ALTHI = 3'd6
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [BSEL_W-1:0] bank;
    } reg_sel_t;

    // Byte offset of one register of one bank; the last bank of the
    // pin-facing words lives in the high window.
    function automatic logic [OFF_W-1:0] reg_offset(reg_kind_e k, int b);
        int  v;
        logic hi;
        hi = (b == NBANK - 1);
        case (k)
            K_LEVEL: v = hi ? 32'h100 : 32'h000 + 4 * b;
            K_DIR:   v = hi ? 32'h10C : 32'h00C + 4 * b;
            K_SET:   v = hi ? 32'h118 : 32'h018 + 4 * b;
            K_CLR:   v = hi ? 32'h124 : 32'h024 + 4 * b;
            K_ALTLO: v = 32'h054 + 8 * b;
            K_ALTHI: v = 32'h058 + 8 * b;
            default: v = 0;
        endcase
        return OFF_W'(v);
    endfunction

    function automatic reg_sel_t decode_offset(logic [OFF_W-1:0] off);
        reg_sel_t s;
        s.kind = K_NONE;
        s.bank = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (off == reg_offset(K_LEVEL, b)) begin s.kind = K_LEVEL; s.bank = BSEL_W'(b); end
            if (off == reg_offset(K_DIR,   b)) begin s.kind = K_DIR;   s.bank = BSEL_W'(b); end
            if (off == reg_offset(K_SET,   b)) begin s.kind = K_SET;   s.bank = BSEL_W'(b); end
            if (off == reg_offset(K_CLR,   b)) begin s.kind = K_CLR;   s.bank = BSEL_W'(b); end
            if (off == reg_offset(K_ALTLO, b)) begin s.kind = K_ALTLO; s.bank = BSEL_W'(b); end
            if (off == reg_offset(K_ALTHI, b)) begin s.kind = K_ALTHI; s.bank = BSEL_W'(b); end
        end
        return s;
    endfunction

    function automatic logic [BANK_W-1:0] merge_level(logic [BANK_W-1:0] latch,
                                                      logic [BANK_W-1:0] dir,
                                                      logic [BANK_W-1:0] pin);
        return (latch & dir) | (pin & ~dir);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 128,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign d_out = stage_q[STAGES-1];

    // R12
    sync_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(stage_q[0]) |=> $past(stage_q[0]) == stage_q[1] || STAGES == 1);
endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_window,
    output logic              unmapped,
    output reg_sel_t          sel
);
    localparam int HI_W = ADDR_W - OFF_W;

    always_comb begin
        in_window = (addr[ADDR_W-1:OFF_W] == HI_W'(0));
        sel       = decode_offset(addr[OFF_W-1:0]);
        if (!in_window) sel.kind = K_NONE;
        unmapped  = in_window && (sel.kind == K_NONE);
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] latch_q,
    output logic [BANK_W-1:0] alt_lo_q,
    output logic [BANK_W-1:0] alt_hi_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= '0;
            latch_q  <= '0;
            alt_lo_q <= '0;
            alt_hi_q <= '0;
        end else if (wr_en) begin
            case (wr_kind)
                K_DIR:   dir_q    <= wdata;
                K_SET:   latch_q  <= latch_q | wdata;
                K_CLR:   latch_q  <= latch_q & ~wdata;
                K_ALTLO: alt_lo_q <= wdata;
                K_ALTHI: alt_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    // R4
    set_or_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == K_SET) |=>
            latch_q == ($past(latch_q) | $past(wdata)));
    // R5
    clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == K_CLR) |=>
            (latch_q & $past(wdata)) == '0 && (latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata)));
    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_kind == K_SET || wr_kind == K_CLR)) |=> $stable(latch_q));
    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_kind == K_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_data,
    output logic              err_flag,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out
);
    logic        in_window;
    logic        unmapped;
    reg_sel_t    sel;
    logic [NPIN-1:0] pin_sync;

    logic [BANK_W-1:0] dir_b   [NBANK];
    logic [BANK_W-1:0] latch_b [NBANK];
    logic [BANK_W-1:0] altlo_b [NBANK];
    logic [BANK_W-1:0] althi_b [NBANK];
    logic [BANK_W-1:0] pin_b   [NBANK];
    logic [BANK_W-1:0] rd_mux;

    gpio_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (req_addr),
        .in_window (in_window),
        .unmapped  (unmapped),
        .sel       (sel)
    );

    gpio_in_sync #(.W(NPIN), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pad_in),
        .d_out (pin_sync)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = req_valid && req_write && (sel.kind != K_NONE)
                         && (sel.bank == BSEL_W'(b));

        gpio_bank_regs u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bank_wr),
            .wr_kind  (sel.kind),
            .wdata    (req_wdata),
            .dir_q    (dir_b[b]),
            .latch_q  (latch_b[b]),
            .alt_lo_q (altlo_b[b]),
            .alt_hi_q (althi_b[b])
        );

        assign pin_b[b] = pin_sync[b*BANK_W +: BANK_W];
        assign pad_out[b*BANK_W +: BANK_W] = latch_b[b] & dir_b[b];
    end

    always_comb begin
        case (sel.kind)
            K_LEVEL: rd_mux = merge_level(latch_b[sel.bank], dir_b[sel.bank], pin_b[sel.bank]);
            K_DIR:   rd_mux = dir_b[sel.bank];
            K_ALTLO: rd_mux = altlo_b[sel.bank];
            K_ALTHI: rd_mux = althi_b[sel.bank];
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            err_flag <= 1'b0;
        end else begin
            rd_valid <= req_valid && !req_write;
            if (req_valid && !req_write) rd_data <= rd_mux;
            if (req_valid && unmapped)   err_flag <= 1'b1;
        end
    end

    // R12
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rd_valid);
    // R12
    rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rd_valid);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
    // R9
    outside_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !in_window) |=> rd_data == '0);
    // R6
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && (sel.kind == K_SET || sel.kind == K_CLR)) |=> rd_data == '0);
    // R8
    pad_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~{dir_b[3], dir_b[2], dir_b[1], dir_b[0]}) == '0);
    // R9
    outside_noerr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !in_window && !err_flag) |=> !err_flag);
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    localparam int NB = 4;
    localparam int BW = 32;
    localparam int NP = NB * BW;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid, req_write;
    logic [11:0]   req_addr;
    logic [31:0]   req_wdata;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic          err_flag;
    logic [NP-1:0] pad_in;
    logic [NP-1:0] pad_out;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_dir [NB];
    logic [31:0] m_lat [NB];
    logic [31:0] m_alo [NB];
    logic [31:0] m_ahi [NB];
    logic        m_err;

    always #2 clk = ~clk;

    gpio_bank_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .err_flag(err_flag), .pad_in(pad_in), .pad_out(pad_out)
    );

    // kinds: 0 level, 1 dir, 2 set, 3 clear, 4 alt low, 5 alt high (R2, R3)
    function automatic logic [11:0] addr_of(int k, int b);
        case (k)
            0: return (b == 3) ? 12'h100 : 12'(4 * b);
            1: return (b == 3) ? 12'h10C : 12'(12'h00C + 4 * b);
            2: return (b == 3) ? 12'h118 : 12'(12'h018 + 4 * b);
            3: return (b == 3) ? 12'h124 : 12'(12'h024 + 4 * b);
            4: return 12'(12'h054 + 8 * b);
            default: return 12'(12'h058 + 8 * b);
        endcase
    endfunction

    function automatic int find_kind(logic [11:0] a, output int bank);
        bank = 0;
        for (int k = 0; k < 6; k++)
            for (int b = 0; b < NB; b++)
                if (a == addr_of(k, b)) begin bank = b; return k; end
        return -1;
    endfunction

    function automatic logic [31:0] exp_level(int b);
        logic [31:0] pin;
        pin = pad_in[b*BW +: BW];
        return (m_lat[b] & m_dir[b]) | (pin & ~m_dir[b]);
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a);
        int b, k;
        if (a >= 12'h200) return '0;
        k = find_kind(a, b);
        case (k)
            0: return exp_level(b);
            1: return m_dir[b];
            4: return m_alo[b];
            5: return m_ahi[b];
            default: return '0;
        endcase
    endfunction

    task automatic model_write(logic [11:0] a, logic [31:0] d);
        int b, k;
        if (a >= 12'h200) return;
        k = find_kind(a, b);
        case (k)
            1: m_dir[b] = d;
            2: m_lat[b] = m_lat[b] | d;
            3: m_lat[b] = m_lat[b] & ~d;
            4: m_alo[b] = d;
            5: m_ahi[b] = d;
            -1: m_err = 1'b1;
            default: ;
        endcase
    endtask

    task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(logic [11:0] a, output logic [31:0] d);
        int b;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        if (a < 12'h200 && find_kind(a, b) < 0) m_err = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
        check(rd_valid === 1'b1, "R12 rd_valid", 128'(rd_valid), 128'(1));
    endtask

    task automatic read_check(logic [11:0] a, string tag);
        logic [31:0] exp, got;
        exp = exp_read(a);
        do_read(a, got);
        check(got === exp, tag, 128'(got), 128'(exp));
    endtask

    task automatic set_pads(logic [NP-1:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [NP-1:0] exp_pads();
        logic [NP-1:0] v;
        for (int b = 0; b < NB; b++) v[b*BW +: BW] = m_lat[b] & m_dir[b];
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] got, old;
        void'($urandom(32'd1234));
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = '0; m_lat[b] = '0; m_alo[b] = '0; m_ahi[b] = '0;
        end
        m_err = 1'b0;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
        pad_in = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check(pad_out === '0, "R11 pad_out", pad_out, '0);
        check(err_flag === 1'b0, "R11 err_flag", 128'(err_flag), 0);
        for (int b = 0; b < NB; b++) begin
            read_check(addr_of(1, b), "R11 dir");
            read_check(addr_of(4, b), "R11 alt lo");
            read_check(addr_of(5, b), "R11 alt hi");
        end

        // R1 pin mapping: all inputs, pin 37 is bank 1 bit 5, pin 127 bank 3 bit 31
        set_pads(NP'(1) << 37 | NP'(1) << 127);
        read_check(addr_of(0, 1), "R1 pin37");
        read_check(addr_of(0, 3), "R1 pin127");
        read_check(addr_of(0, 0), "R1 bank0 quiet");

        // R4 R5 R8 directed set/clear on bank 3
        do_write(addr_of(1, 3), 32'hFFFF_0000);
        do_write(addr_of(2, 3), 32'h00FF_00FF);
        do_write(addr_of(2, 3), 32'h0F00_0000);
        read_check(addr_of(0, 3), "R4 set or");
        do_write(addr_of(3, 3), 32'h0001_0001);
        read_check(addr_of(0, 3), "R5 clear");
        check(pad_out === exp_pads(), "R8 pad gating", pad_out, exp_pads());
        check(pad_out[127:96] === 32'h0FFE_0000, "R1 R8 bank3 pads", 128'(pad_out[127:96]), 128'(32'h0FFE_0000));

        // R6 write-only words read zero
        read_check(addr_of(2, 3), "R6 set rd");
        read_check(addr_of(3, 3), "R6 clr rd");

        // R2 level write ignored
        do_write(addr_of(0, 3), 32'hFFFF_FFFF);
        read_check(addr_of(0, 3), "R2 level ro");

        // R9 out-of-window ignored
        do_write(12'h200 | addr_of(1, 0), 32'hFFFF_FFFF);
        read_check(addr_of(1, 0), "R9 no alias");
        read_check(12'h318, "R9 read zero");
        check(err_flag === 1'b0, "R9 no err", 128'(err_flag), 0);

        // R3 alternate words
        do_write(addr_of(4, 2), 32'hDEAD_BEEF);
        do_write(addr_of(5, 2), 32'h1234_5678);
        read_check(addr_of(4, 2), "R3 alt lo");
        read_check(addr_of(5, 2), "R3 alt hi");

        // R10 unmapped below window
        do_write(12'h0A0, 32'hFFFF_FFFF);
        check(err_flag === 1'b1, "R10 err set", 128'(err_flag), 1);
        read_check(12'h0A0, "R10 read zero");
        read_check(12'h002, "R10 unaligned");
        check(err_flag === 1'b1, "R10 sticky", 128'(err_flag), 1);

        // R12 sync latency: pad change and read in the same cycle sees old value
        do_write(addr_of(1, 0), 32'h0);
        old = exp_level(0);
        @(negedge clk);
        pad_in[31:0] = ~pad_in[31:0];
        req_valid = 1'b1; req_write = 1'b0; req_addr = addr_of(0, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check(rd_data === old, "R12 sync old", 128'(rd_data), 128'(old));
        repeat (3) @(negedge clk);
        read_check(addr_of(0, 0), "R12 sync new");

        // R7 random traffic
        for (int i = 0; i < 400; i++) begin
            int op, k, b;
            logic [11:0] a;
            op = $urandom_range(0, 9);
            k  = $urandom_range(0, 5);
            b  = $urandom_range(0, 3);
            a  = addr_of(k, b);
            if (op == 0) set_pads({$urandom, $urandom, $urandom, $urandom});
            else if (op == 1) a = 12'($urandom);
            if (op <= 4) do_write(a, $urandom);
            else read_check(a, (k == 0) ? "R7 level merge" : "R2 R3 random read");
            if (op == 9) check(pad_out === exp_pads(), "R8 random pads", pad_out, exp_pads());
        end
        check(err_flag === m_err, "R10 final err", 128'(err_flag), 128'(m_err));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule